// File: doc/BRIEF.md
# Control Register Writer with Banked Stack Pointers

This block takes writes aimed at the processor's control registers and keeps the two banked stack pointers behind the live A7 register. A write presents a 12-bit register number, a data word and a strobe. Two register numbers are stored: the cache control word and the vector base. Four numbers that would select the access control registers are accepted and ignored. Any other number is rejected with a one-cycle error pulse and changes nothing.

The stack in use is the supervisor stack only when the supervisor status input is high and a separate-stack enable bit in the cache control word (bit `SEP_BIT`, 5 by default) is set. In every other case the user stack is used. The choice is made again on every cache control write and on every change of the supervisor input. Each time, the live A7 is first saved into the slot of the stack that was active, then reloaded from the slot just chosen. At other times the rest of the core may overwrite A7 through its own write port.

Top module: `ctlreg_stack_bank`

## Requirements
- R1: In reset and on leaving it, the cache control word, vector base, A7 and error output are zero and the user stack is active (`sup_active` = 0).
- R2: A strobed write to register number 0x002 loads `wr_data` into `cache_ctl`, seen on the next cycle.
- R3: A strobed write to register number 0x801 loads `wr_data` into `vec_base`, seen on the next cycle.
- R4: A strobed write to register numbers 0x004, 0x005, 0x006 or 0x007 raises no error and leaves `cache_ctl`, `vec_base` and `a7` unchanged.
- R5: A strobed write to any other register number sets `bad_wr` high for exactly the next cycle and changes no register; with no strobe `bad_wr` stays low.
- R6: After every re-selection, `sup_active` is 1 exactly when the supervisor input is 1 and bit `SEP_BIT` of the (updated) cache control word is 1.
- R7: A cache control write re-selects the stack: A7 is saved into the slot of the stack that was active and then loaded from the newly chosen slot, in the same cycle.
- R8: A change of the supervisor input triggers the same save-and-reload as R7.
- R9: When no re-selection happens, `a7_we` loads `a7_wdata` into A7 on the next cycle.
- R10: When `a7_we` coincides with a re-selection, `a7_wdata` is the value saved into the outgoing slot; A7 then holds the chosen slot's value, which is `a7_wdata` itself when the chosen stack is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_sel | input | 12 | Control register number |
| wr_data | input | 32 | Value to write |
| super_bit | input | 1 | Supervisor status bit |
| a7_we | input | 1 | Core write strobe for A7 |
| a7_wdata | input | 32 | Value the core writes to A7 |
| cache_ctl | output | 32 | Cache control word |
| vec_base | output | 32 | Vector base |
| a7 | output | 32 | Live stack pointer |
| sup_active | output | 1 | 1 when the supervisor slot is the active one |
| bad_wr | output | 1 | One-cycle pulse after a write to an unknown register number |

## Verification
The case that matters most is a core write to A7 in the same cycle as a stack re-selection, whether that re-selection comes from a cache control write or from a toggle of the supervisor input. The bench sets both up together: first in a directed sequence, where the stack changes and where it stays the same, and then in a long pseudo-random run that sets the supervisor input, the enable bit and the A7 strobe independently. A bench model holds the two slots and the active index and predicts the A7 value after each step. A saved value that went to the wrong slot shows up later, when that slot is loaded back into A7.

// File: rtl/ctlreg_stack_bank.sv
module ctlreg_stack_bank #(
  parameter int DW      = 32,
  parameter int RW      = 12,
  parameter int SEP_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          super_bit,
  input  logic          a7_we,
  input  logic [DW-1:0] a7_wdata,
  output logic [DW-1:0] cache_ctl,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] a7,
  output logic          sup_active,
  output logic          bad_wr
);
  localparam logic [RW-1:0] SEL_CC = RW'(12'h002);
  localparam logic [RW-1:0] SEL_VB = RW'(12'h801);

  logic [DW-1:0] usp_slot, ssp_slot;
  logic          super_q;

  wire hit_cc  = wr_en && (wr_sel == SEL_CC);
  wire hit_vb  = wr_en && (wr_sel == SEL_VB);
  wire hit_acr = wr_en && ((wr_sel >> 2) == RW'(1));
  wire unknown = wr_en && !(hit_cc || hit_vb || hit_acr);

  wire [DW-1:0] cc_next  = hit_cc ? wr_data : cache_ctl;
  wire          reselect = hit_cc || (super_bit != super_q);
  wire          next_sup = super_bit && cc_next[SEP_BIT];
  wire [DW-1:0] save_val = a7_we ? a7_wdata : a7;
  wire [DW-1:0] load_val = (next_sup == sup_active) ? save_val
                         : (next_sup ? ssp_slot : usp_slot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cache_ctl  <= '0;
      vec_base   <= '0;
      usp_slot   <= '0;
      ssp_slot   <= '0;
      a7         <= '0;
      sup_active <= 1'b0;
      super_q    <= 1'b0;
      bad_wr     <= 1'b0;
    end else begin
      super_q <= super_bit;
      bad_wr  <= unknown;
      if (hit_cc) cache_ctl <= wr_data;
      if (hit_vb) vec_base  <= wr_data;
      if (reselect) begin
        if (sup_active) ssp_slot <= save_val;
        else            usp_slot <= save_val;
        a7         <= load_val;
        sup_active <= next_sup;
      end else if (a7_we) begin
        a7 <= a7_wdata;
      end
    end
  end

  // R2
  cc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_sel) == SEL_CC) |-> cache_ctl == $past(wr_data));

  // R3
  vb_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_sel) == SEL_VB) |-> vec_base == $past(wr_data));

  // R5
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |-> ($stable(cache_ctl) && $stable(vec_base) && $past(wr_en)));

  // R5
  bad_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en)) |-> !bad_wr);

  // R6
  sel_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_active == (super_q && cache_ctl[SEP_BIT]));

  // R9
  a7_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(a7_we) && !$past(wr_en) && $past(super_bit) == super_q && $stable(super_q))
      |-> a7 == $past(a7_wdata));
endmodule

// File: tb/ctlreg_stack_bank_test.sv
module ctlreg_stack_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int SEP = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        super_bit = 1'b0;
  logic        a7_we = 1'b0;
  logic [31:0] a7_wdata = '0;
  logic [31:0] cache_ctl, vec_base, a7;
  logic        sup_active, bad_wr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] m_cc = '0, m_vb = '0, m_usp = '0, m_ssp = '0, m_a7 = '0;
  logic        m_sup = 1'b0, m_superq = 1'b0, m_bad = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  ctlreg_stack_bank #(.DW(32), .RW(12), .SEP_BIT(SEP)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .super_bit(super_bit), .a7_we(a7_we), .a7_wdata(a7_wdata),
    .cache_ctl(cache_ctl), .vec_base(vec_base), .a7(a7),
    .sup_active(sup_active), .bad_wr(bad_wr));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [11:0] sel, input logic [31:0] d,
                      input logic sb, input logic awe, input logic [31:0] ad);
    logic        hcc, hvb, hacr, resel, nsup;
    logic [31:0] ncc, save, load;
    string       a7tag;
    wr_en = we; wr_sel = sel; wr_data = d; super_bit = sb; a7_we = awe; a7_wdata = ad;
    hcc  = we && sel == 12'h002;
    hvb  = we && sel == 12'h801;
    hacr = we && sel >= 12'h004 && sel <= 12'h007;
    ncc  = hcc ? d : m_cc;
    resel = hcc || (sb != m_superq);
    nsup = sb && ncc[SEP];
    save = awe ? ad : m_a7;
    a7tag = !resel ? "R9" : (awe ? "R10" : (hcc ? "R7" : "R8"));
    m_bad = we && !(hcc || hvb || hacr);
    if (resel) begin
      load = (nsup == m_sup) ? save : (nsup ? m_ssp : m_usp);
      if (m_sup) m_ssp = save; else m_usp = save;
      m_a7 = load;
      m_sup = nsup;
    end else if (awe) m_a7 = ad;
    m_cc = ncc;
    if (hvb) m_vb = d;
    m_superq = sb;
    @(posedge clk);
    @(negedge clk);
    check(hacr ? "R4 cache_ctl" : "R2 cache_ctl", cache_ctl, m_cc);
    check(hacr ? "R4 vec_base" : "R3 vec_base", vec_base, m_vb);
    check(hacr ? "R4 bad_wr" : "R5 bad_wr", {31'd0, bad_wr}, {31'd0, m_bad});
    check("R6 sup_active", {31'd0, sup_active}, {31'd0, m_sup});
    check(a7tag, a7, m_a7);
    wr_en = 1'b0; a7_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cache_ctl", cache_ctl, 32'd0);
    check("R1 vec_base", vec_base, 32'd0);
    check("R1 a7", a7, 32'd0);
    check("R1 sup_active", {31'd0, sup_active}, 32'd0);
    check("R1 bad_wr", {31'd0, bad_wr}, 32'd0);
    rst_n = 1'b1;
    step(1'b0, 12'h000, 32'd0, 1'b0, 1'b0, 32'd0);
    check("R5 no strobe", {31'd0, bad_wr}, 32'd0);

    // R10 directed: stack change and no change with coincident A7 write
    step(1'b0, 12'h000, 32'd0, 1'b0, 1'b1, 32'hAAAA_0001);
    step(1'b1, 12'h002, 32'h0000_0020, 1'b1, 1'b1, 32'hAAAA_0002);
    check("R10 supervisor slot loaded", a7, 32'd0);
    step(1'b0, 12'h000, 32'd0, 1'b1, 1'b1, 32'h5555_0003);
    step(1'b0, 12'h000, 32'd0, 1'b0, 1'b0, 32'd0);
    check("R8 user slot restored", a7, 32'hAAAA_0002);
    step(1'b0, 12'h000, 32'd0, 1'b1, 1'b0, 32'd0);
    check("R8 supervisor slot restored", a7, 32'h5555_0003);
    step(1'b1, 12'h002, 32'h0000_0020, 1'b1, 1'b1, 32'h7777_0004);
    check("R10 same stack keeps written value", a7, 32'h7777_0004);
    step(1'b1, 12'h002, 32'h0000_0000, 1'b1, 1'b0, 32'd0);
    check("R7 enable cleared gives user slot", a7, 32'hAAAA_0002);

    // exhaustive sweep of register numbers
    for (int n = 0; n < 4096; n++) begin
      rng = nxt(rng);
      step(1'b1, n[11:0], rng, rng[7], rng[9], nxt(rng));
    end

    // random mix of supervisor toggles, enable changes and A7 writes
    for (int k = 0; k < 3000; k++) begin
      rng = nxt(rng);
      step(rng[0], rng[1] ? 12'h002 : {rng[20:18], 9'd0}, {rng[31:6], rng[2], rng[4:0]},
           rng[3], rng[4], nxt(rng));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule